// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM Core

This block is a synthesizable model of a small synchronous SRAM. It is built from 32-bit words, each split into four byte lanes, and it has one address/control port. On each clock edge it decodes one cycle type from these inputs: select, advance/load, write, the byte enables and the hold input.

A load cycle captures an external address and starts a four-beat burst. Advance cycles then step the two low address bits. The step order is linear or interleaved, and an order input chooses between them.

Reads and writes share a single tri-state data bus, and both have the same two-clock pipeline. Read data is driven two non-held edges after its address cycle. Write data is taken from the bus at that same distance. Because of this, a read can follow a write, or a write can follow a read, on the very next cycle with no idle cycle between them.

A hold input freezes the whole block as a wait state. A write with no byte enabled is an abort. A read taken while output enable is low is a dummy read. A sleep input forces the bus off.

Top module: `zbt_sram`

## Requirements
- R1: Reset is synchronous and active high. After reset the block is deselected and `dq_oe` is low, whatever the value of `oe`.
- R2: A load cycle is a cycle with `hold` low, `adv` low and `sel` high. It captures `addr` as the first burst address. `wr`=1 makes the burst a write and `wr`=0 makes it a read.
- R3: A cycle with `adv` high and `hold` low moves to the next burst address. It keeps the upper address bits (above bit 1) and the read/write direction, and it ignores `sel` and `wr`. An advance that follows a deselect (`sel` low with `adv` low) stays deselected.
- R4: With `interleave`=0, beat n of a burst uses low address bits (start + n) mod 4. For example, a burst starting at 2 goes 2, 3, 0, 1.
- R5: With `interleave`=1, beat n uses low address bits start XOR n. For example, a burst starting at 1 goes 1, 0, 3, 2.
- R6: The read data for an address cycle is driven on `dq` after the second non-held rising edge that follows that cycle. It stays on the bus until the next non-held edge.
- R7: Write data is sampled from `dq` at the second non-held rising edge after its address cycle. Each set bit i of `byte_en` updates only bits [8i+7:8i] of the addressed word.
- R8: A write beat with `byte_en` all zero is an abort. It leaves the word unchanged, on load beats and on advance beats alike.
- R9: A read beat whose data slot falls while `oe` is low is a dummy read. The bus is not driven, and the burst address still advances.
- R10: While `hold` is high, the clock edge is ignored. The burst, address, pipeline and read data all keep their values, so the bus keeps driving the same value.
- R11: `sleep` high forces `dq_oe` low at once.
- R12: `oe` acts combinationally. The block never drives `dq` while a write beat holds the data slot.
- R13: A read of the word written by the immediately preceding cycle returns the newly written bytes, with no idle cycle between the two.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| hold | input | 1 | Wait state: ignore this edge |
| sel | input | 1 | Chip select for load cycles |
| adv | input | 1 | 1 = advance the burst, 0 = load or deselect |
| wr | input | 1 | Burst direction on load: 1 write, 0 read |
| byte_en | input | LANES | Per-lane write enables |
| addr | input | ADDR_W | Word address for load cycles |
| interleave | input | 1 | Burst order: 1 interleaved, 0 linear |
| oe | input | 1 | Asynchronous output enable |
| sleep | input | 1 | Forces the bus to high impedance |
| dq | inout | 8*LANES | Shared read/write data bus |
| dq_oe | output | 1 | High while the block drives `dq` |

## Verification
On every cycle, the assertions check the following. The address captured by a load is correct. A linear advance steps the low bits by one, and the upper bits stay put during a burst. Hold freezes the control state. Reset leaves the bus undriven. A write cycle never produces a drive two edges later, and a read drives exactly when `oe` and not `sleep`.

Some behaviours only the bench scenarios can show. The first is the data content: partial-lane merges and aborted writes. The others are the interleaved order, the dummy-read advance, the same-word write-then-read forwarding, and the bus value held through a stall.

// File: rtl/zsr_pkg.sv
package zsr_pkg;

    localparam int LANE_W     = 8;
    localparam int BURST_BITS = 2;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // Low address bits for beat 'step' of a burst starting at 'first'
    function automatic logic [BURST_BITS-1:0] burst_lsb(
        input logic [BURST_BITS-1:0] first,
        input logic [BURST_BITS-1:0] step,
        input logic                  xor_order
    );
        return xor_order ? (first ^ step) : (first + step);
    endfunction

endpackage

// File: rtl/zsr_cycle_ctl.sv
module zsr_cycle_ctl
    import zsr_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hold,
    input  logic              sel,
    input  logic              adv,
    input  logic              wr,
    input  logic [LANES-1:0]  byte_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              interleave,
    output op_e               s1_op,
    output logic [ADDR_W-1:0] s1_addr,
    output logic [LANES-1:0]  s1_be
);

    logic [BURST_BITS-1:0] first_q;
    logic [BURST_BITS-1:0] beat_q;
    logic [BURST_BITS-1:0] beat_nx;

    assign beat_nx = beat_q + 2'd1;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_op   <= OP_IDLE;
            s1_addr <= '0;
            s1_be   <= '0;
            first_q <= '0;
            beat_q  <= '0;
        end else if (!hold) begin
            s1_be <= byte_en;
            if (!adv) begin
                if (sel) begin
                    s1_op   <= wr ? OP_WRITE : OP_READ;
                    s1_addr <= addr;
                    first_q <= addr[BURST_BITS-1:0];
                    beat_q  <= '0;
                end else begin
                    s1_op <= OP_IDLE;
                end
            end else if (s1_op != OP_IDLE) begin
                beat_q                     <= beat_nx;
                s1_addr[BURST_BITS-1:0]    <= burst_lsb(first_q, beat_nx, interleave);
            end
        end
    end

endmodule

// File: rtl/zsr_store.sv
module zsr_store
    import zsr_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int LANES  = 4
) (
    input  logic                     clk,
    input  logic                     wr_go,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [LANES-1:0]         wr_be,
    input  logic [LANES*LANE_W-1:0]  wr_data,
    input  logic                     rd_go,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [LANES*LANE_W-1:0]  rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic same_word;
    assign same_word = wr_go && (wr_addr == rd_addr);

    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        logic [LANE_W-1:0] bank [DEPTH];
        logic [LANE_W-1:0] rd_q;

        always_ff @(posedge clk) begin
            if (wr_go && wr_be[ln])
                bank[wr_addr] <= wr_data[ln*LANE_W +: LANE_W];
            if (rd_go)
                rd_q <= (same_word && wr_be[ln]) ? wr_data[ln*LANE_W +: LANE_W]
                                                 : bank[rd_addr];
        end

        assign rd_data[ln*LANE_W +: LANE_W] = rd_q;
    end

endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
    import zsr_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hold,
    input  logic              sel,
    input  logic              adv,
    input  logic              wr,
    input  logic [LANES-1:0]  byte_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              interleave,
    input  logic              oe,
    input  logic              sleep,
    inout  wire  [LANES*8-1:0] dq,
    output logic              dq_oe
);

    localparam int DATA_W = LANES * LANE_W;

    op_e               s1_op;
    logic [ADDR_W-1:0] s1_addr;
    logic [LANES-1:0]  s1_be;

    op_e               s2_op;
    logic [ADDR_W-1:0] s2_addr;
    logic [LANES-1:0]  s2_be;

    logic [DATA_W-1:0] rd_data;

    zsr_cycle_ctl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctl (
        .clk        (clk),
        .rst        (rst),
        .hold       (hold),
        .sel        (sel),
        .adv        (adv),
        .wr         (wr),
        .byte_en    (byte_en),
        .addr       (addr),
        .interleave (interleave),
        .s1_op      (s1_op),
        .s1_addr    (s1_addr),
        .s1_be      (s1_be)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_op   <= OP_IDLE;
            s2_addr <= '0;
            s2_be   <= '0;
        end else if (!hold) begin
            s2_op   <= s1_op;
            s2_addr <= s1_addr;
            s2_be   <= s1_be;
        end
    end

    zsr_store #(.ADDR_W(ADDR_W), .LANES(LANES)) u_store (
        .clk     (clk),
        .wr_go   (!hold && !rst && s2_op == OP_WRITE),
        .wr_addr (s2_addr),
        .wr_be   (s2_be),
        .wr_data (dq),
        .rd_go   (!hold && !rst && s1_op == OP_READ),
        .rd_addr (s1_addr),
        .rd_data (rd_data)
    );

    assign dq_oe = (s2_op == OP_READ) && oe && !sleep;
    assign dq    = dq_oe ? rd_data : {DATA_W{1'bz}};

endmodule

// File: rtl/zsr_checker.sv
module zsr_checker
    import zsr_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              hold,
    input logic              sel,
    input logic              adv,
    input logic              wr,
    input logic              interleave,
    input logic              oe,
    input logic              sleep,
    input logic [ADDR_W-1:0] addr,
    input op_e               s1_op,
    input logic [ADDR_W-1:0] s1_addr,
    input op_e               s2_op,
    input logic              dq_oe
);

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (s2_op == OP_IDLE && !dq_oe)); // R1

    AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (rst)
        (!hold && !adv && sel) |=> (s1_addr == $past(addr))); // R2

    AST_BURST_UPPER: assert property (@(posedge clk) disable iff (rst)
        (!hold && adv) |=> $stable(s1_addr[ADDR_W-1:2])); // R3

    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (rst)
        (!hold && adv && s1_op != OP_IDLE && !interleave)
        |=> (s1_addr[1:0] == 2'($past(s1_addr[1:0]) + 2'd1))); // R4

    AST_READ_DRIVES: assert property (@(posedge clk) disable iff (rst)
        (!hold && !adv && sel && !wr) ##1 !hold |=> (dq_oe == (oe && !sleep))); // R6

    AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!hold && !adv && sel && wr) ##1 !hold |=> !dq_oe); // R12

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        hold |=> ($stable(s1_addr) && $stable(s1_op) && $stable(s2_op))); // R10

endmodule

bind zbt_sram zsr_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .hold       (hold),
    .sel        (sel),
    .adv        (adv),
    .wr         (wr),
    .interleave (interleave),
    .oe         (oe),
    .sleep      (sleep),
    .addr       (addr),
    .s1_op      (s1_op),
    .s1_addr    (s1_addr),
    .s2_op      (s2_op),
    .dq_oe      (dq_oe)
);

// File: tb/zbt_sram_test.sv
`timescale 1ns/1ps
module zbt_sram_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hold = 1'b0, sel = 1'b0, adv = 1'b0, wr = 1'b0;
    logic [3:0]  byte_en = 4'h0;
    logic [3:0]  addr = 4'h0;
    logic        interleave = 1'b0, oe = 1'b1, sleep = 1'b0;
    wire  [31:0] dq;
    logic        dq_oe;
    logic [31:0] tb_d = 32'h0;
    logic        tb_en = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    assign dq = tb_en ? tb_d : 32'hzzzz_zzzz;

    always #2 clk = ~clk;

    zbt_sram uut (
        .clk(clk), .rst(rst), .hold(hold), .sel(sel), .adv(adv), .wr(wr),
        .byte_en(byte_en), .addr(addr), .interleave(interleave), .oe(oe),
        .sleep(sleep), .dq(dq), .dq_oe(dq_oe)
    );

    typedef struct packed {
        logic [3:0]  a;
        logic [3:0]  be;
        logic [31:0] d;
        logic [31:0] exp;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{4'd3,  4'b0001, 32'h1122_3344, 32'hA5A5_A544},
        '{4'd5,  4'b1100, 32'hDEAD_BEEF, 32'hDEAD_A5A5},
        '{4'd9,  4'b0000, 32'hFFFF_FFFF, 32'hA5A5_A5A5},
        '{4'd12, 4'b1111, 32'h0BAD_F00D, 32'h0BAD_F00D},
        '{4'd14, 4'b1010, 32'h1234_5678, 32'h12A5_56A5}
    };

    localparam logic [31:0] D0 = 32'h1000_0001;
    localparam logic [31:0] D1 = 32'h2000_0002;
    localparam logic [31:0] D2 = 32'h3000_0003;
    localparam logic [31:0] D3 = 32'h4000_0004;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic idle();
        sel = 1'b0; adv = 1'b0; wr = 1'b0; byte_en = 4'h0;
    endtask

    task automatic load(input logic w, input logic [3:0] a, input logic [3:0] be);
        sel = 1'b1; adv = 1'b0; wr = w; addr = a; byte_en = be;
    endtask

    task automatic release_after_edge();
        @(posedge clk);
        #1 tb_en = 1'b0;
    endtask

    task automatic write_word(input logic [3:0] a, input logic [3:0] be, input logic [31:0] d);
        load(1'b1, a, be);
        tick();
        idle();
        tick();
        tb_d = d; tb_en = 1'b1;
        release_after_edge();
        tick();
    endtask

    task automatic read_word(input logic [3:0] a, output logic [31:0] got);
        load(1'b0, a, 4'h0);
        tick();
        idle();
        tick();
        got = dq;
        tick();
    endtask

    initial begin
        logic [31:0] got;

        repeat (3) tick();
        chk("R1 bus off in reset", {31'b0, dq_oe}, 32'd0);
        rst = 1'b0;
        tick();
        chk("R1 bus off after reset with oe high", {31'b0, dq_oe}, 32'd0);

        // table of partial writes and aborts (R7, R8)
        for (int i = 0; i < 5; i++) begin
            write_word(VECS[i].a, 4'hF, 32'hA5A5_A5A5);
            write_word(VECS[i].a, VECS[i].be, VECS[i].d);
            read_word(VECS[i].a, got);
            chk(VECS[i].be == 4'h0 ? "R8 abort keeps word" : "R7 lane merge", got, VECS[i].exp);
        end

        // linear write burst from 6: 6,7,4,5 (R4, R2, R12)
        interleave = 1'b0;
        load(1'b1, 4'd6, 4'hF);
        tick();
        adv = 1'b1; sel = 1'b0; wr = 1'b0;
        tick();
        tb_d = D0; tb_en = 1'b1;
        tick();
        chk("R12 no drive during write", {31'b0, dq_oe}, 32'd0);
        tb_d = D1;
        tick();
        tb_d = D2; idle();
        tick();
        tb_d = D3;
        release_after_edge();
        tick();
        read_word(4'd6, got); chk("R4 linear beat0", got, D0);
        read_word(4'd7, got); chk("R4 linear beat1", got, D1);
        read_word(4'd4, got); chk("R4 linear wrap beat2", got, D2);
        read_word(4'd5, got); chk("R2 R4 linear beat3", got, D3);

        // interleaved read burst from 5: 5,4,7,6 (R5, R3 with wr toggled)
        interleave = 1'b1;
        load(1'b0, 4'd5, 4'h0);
        tick();
        adv = 1'b1; wr = 1'b1; sel = 1'b0;
        tick(); chk("R5 interleave beat0", dq, D3);
        tick(); chk("R5 interleave beat1", dq, D2);
        tick(); chk("R3 R5 direction kept beat2", dq, D1);
        idle();
        tick(); chk("R5 interleave beat3", dq, D0);
        tick();

        // advance after deselect stays deselected (R3)
        idle(); adv = 1'b1; sel = 1'b1; wr = 1'b0;
        tick(); tick(); tick();
        chk("R3 advance after deselect no drive", {31'b0, dq_oe}, 32'd0);
        idle();
        tick();

        // stall during linear read burst from 4 (R10, R6)
        interleave = 1'b0;
        load(1'b0, 4'd4, 4'h0);
        tick();
        adv = 1'b1; sel = 1'b0;
        tick(); chk("R6 read data after two edges", dq, D2);
        hold = 1'b1;
        tick(); chk("R10 held data", dq, D2);
        tick(); chk("R10 held drive", {31'b0, dq_oe}, 32'd1);
        hold = 1'b0;
        tick(); chk("R10 resume next beat", dq, D3);
        idle();
        tick(); chk("R6 last beat after deselect", dq, D0);
        tick();

        // dummy read: oe low on first beats, address keeps moving (R9)
        oe = 1'b0;
        load(1'b0, 4'd6, 4'h0);
        tick();
        adv = 1'b1; sel = 1'b0;
        tick(); chk("R9 dummy beat0 no drive", {31'b0, dq_oe}, 32'd0);
        tick(); chk("R9 dummy beat1 no drive", {31'b0, dq_oe}, 32'd0);
        tick();
        oe = 1'b1;
        #1 chk("R9 R12 oe combinational beat2", dq, D2);
        idle();
        tick(); chk("R9 advanced beat3", dq, D3);
        tick();

        // sleep forces bus off (R11)
        load(1'b0, 4'd4, 4'h0);
        tick();
        idle();
        tick();
        sleep = 1'b1;
        #1 chk("R11 sleep quiets bus", {31'b0, dq_oe}, 32'd0);
        sleep = 1'b0;
        #1 chk("R11 bus back after sleep", dq, D2);
        tick();

        // write then read of same word, back to back (R13)
        write_word(4'd10, 4'hF, 32'h0000_0000);
        load(1'b1, 4'd10, 4'b0110);
        tick();
        load(1'b0, 4'd10, 4'h0);
        tick();
        idle();
        tb_d = 32'hFACE_CAFE; tb_en = 1'b1;
        release_after_edge();
        tick();
        chk("R13 forwarded write data", dq, 32'h00CE_CA00);
        tick();

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule